// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block sequences an external dual-slope integrating converter. Three select outputs steer an analog switch: one shorts the integrator capacitor, one connects the unknown input, and one connects the reference. A single comparator bit comes back from the analog side. The block times the input integration on a prescaled timebase. It then applies the reference and counts system clocks until the comparator falls. That clock count is the raw reading.

The controller keeps an offset of its own. Before the first measurement after reset it runs a zero conversion, in which the integration phase has every select off. It runs another zero conversion once `ZERO_EVERY` measurements have completed, and another whenever the conversion mode differs from the mode of the stored offset. The stored count is subtracted from every later reading. Comparator delay, synchronizer latency and integrator offset therefore drop out.

A two-pass mode reduces the error from dielectric absorption. Each input integration lasts half the programmed length. After the first crossing, the reference stays on for a programmed extra time so that the integrator swings past zero. A second integration and a final rundown follow, and the raw reading is the sum of both rundowns plus the extra time.

The result leaves as a flow with no back-pressure. `res_valid` is high for exactly one clock per finished measurement, and the consumer must capture `res_data` in that cycle. There is no ready input.

Top module: `dsadc_sequencer`

## Requirements
- R1: After reset, all three selects, `res_valid` and `overrange` are low.
- R2: Every conversion starts with `sel_short` high for exactly `SHORT_TICKS * tick_div` clocks.
- R3: The input integration lasts exactly `integ_ticks * tick_div` clocks in single mode. In two-pass mode there are two integrations of `(integ_ticks >> 1) * tick_div` clocks each.
- R4: At most one select is high at any time. Between two different selects, at least one clock passes with all selects off.
- R5: A rundown holds `sel_ref` high until the first falling edge (1 to 0) of the two-flop-synchronized `cmp_in`. Its length is the comparator delay plus a constant latency.
- R6: A zero conversion, whose integration phase has all selects off, comes before the requested measurement in three cases: on the first request after reset, once `ZERO_EVERY` measurements have completed since the last zero, and when `two_pass` differs from the mode of the stored zero.
- R7: `res_data` is the signed raw count minus the latest stored zero count, and it may be negative.
- R8: In two-pass mode, the reference stays on for exactly `overshoot_clks` further clocks after the first crossing. The raw reading is the first rundown plus `overshoot_clks` plus the final rundown.
- R9: If a rundown reaches `rundown_max` clocks without a comparator edge, `overrange` pulses for one clock, no result is produced, and a capacitor-short phase follows before the block goes idle.
- R10: `res_valid` is one clock wide. It appears once per completed measurement and never for a zero conversion.
- R11: `conv_go` is ignored while a conversion is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_go | input | 1 | Request one measurement (sampled when idle) |
| two_pass | input | 1 | 1 selects two-pass conversion mode |
| tick_div | input | DIV_W | Clocks per timebase tick (0 behaves as 1) |
| integ_ticks | input | TK_W | Input integration length in ticks |
| overshoot_clks | input | CNT_W | Extra reference clocks in two-pass mode (at least 1) |
| rundown_max | input | CNT_W | Rundown length limit in clocks |
| cmp_in | input | 1 | Comparator, high while integrator is above threshold |
| sel_short | output | 1 | Capacitor short switch select |
| sel_input | output | 1 | Input switch select |
| sel_ref | output | 1 | Reference switch select |
| res_data | output | CNT_W+3 | Signed, offset-corrected reading |
| res_valid | output | 1 | One-clock result strobe |
| overrange | output | 1 | One-clock overrange strobe |

## Verification
The bench builds the block with `CNT_W=12`, `DIV_W=8`, `TK_W=12`, `SHORT_TICKS=2` and `ZERO_EVERY=3`. It runs with a tick of 4 clocks, 10-tick integrations, a 7-clock overshoot and a 200-clock rundown limit. With a zero period of three, both the periodic refresh and the mode-change refresh of the offset occur within a few conversions. The short timebase keeps each phase length small enough to be compared clock for clock. A behavioral comparator drops its output a chosen number of clocks after each rundown starts. The expected readings are therefore exact differences of those delays, and negative results and overrange can both be provoked.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SHORT,
    PH_GAP,
    PH_INTEG,
    PH_RUND,
    PH_OVER,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/dsadc_tick_gen.sv
module dsadc_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  always_comb begin
    lim  = (div == '0) ? '0 : div - DIV_W'(1);
    tick = !clr && (cnt_q == lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + DIV_W'(1);
  end

  // R3: a cleared timebase cannot tick on the next cycle unless the period is one clock
  a_r3_tick_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && div > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/dsadc_cmp_sync.sv
module dsadc_cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_raw,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], cmp_raw};
  end

  assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/dsadc_zero_store.sv
module dsadc_zero_store #(
  parameter int ACC_W      = 22,
  parameter int ZERO_EVERY = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_req,
  input  logic             store,
  input  logic [ACC_W-1:0] store_val,
  input  logic             store_mode,
  input  logic             meas_done,
  output logic             need_zero,
  output logic [ACC_W-1:0] offset
);
  localparam int MC_W = $clog2(ZERO_EVERY + 1);

  logic            ok_q;
  logic            mode_q;
  logic [MC_W-1:0] mcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q   <= 1'b0;
      mode_q <= 1'b0;
      mcnt_q <= '0;
      offset <= '0;
    end else if (store) begin
      ok_q   <= 1'b1;
      mode_q <= store_mode;
      mcnt_q <= '0;
      offset <= store_val;
    end else if (meas_done && mcnt_q < MC_W'(ZERO_EVERY)) begin
      mcnt_q <= mcnt_q + MC_W'(1);
    end
  end

  assign need_zero = !ok_q || (mode_q != mode_req) || (mcnt_q == MC_W'(ZERO_EVERY));

  // R6: the measurement count since the last zero never passes the refresh period
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    mcnt_q <= MC_W'(ZERO_EVERY));
endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer
  import dsadc_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int DIV_W       = 16,
  parameter int TK_W        = 16,
  parameter int SHORT_TICKS = 4,
  parameter int ZERO_EVERY  = 100,
  localparam int ACC_W      = CNT_W + 2,
  localparam int RES_W      = ACC_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    conv_go,
  input  logic                    two_pass,
  input  logic [DIV_W-1:0]        tick_div,
  input  logic [TK_W-1:0]         integ_ticks,
  input  logic [CNT_W-1:0]        overshoot_clks,
  input  logic [CNT_W-1:0]        rundown_max,
  input  logic                    cmp_in,
  output logic                    sel_short,
  output logic                    sel_input,
  output logic                    sel_ref,
  output logic signed [RES_W-1:0] res_data,
  output logic                    res_valid,
  output logic                    overrange
);
  phase_e           st_q, after_q;
  logic             is_zero_q, two_q, second_q, abort_q;
  logic [CNT_W-1:0] rcnt_q;
  logic [TK_W-1:0]  tcnt_q;
  logic [ACC_W-1:0] acc_q;
  logic             tick, fall, need_zero, clr_tb;
  logic [ACC_W-1:0] offset;
  logic             store_zero, meas_done;
  logic [TK_W:0]    integ_tgt;
  logic             integ_end, short_end, over_end, rund_limit;
  logic [2:0]       sel_now;

  assign clr_tb = (st_q == PH_GAP) || (st_q == PH_IDLE);

  dsadc_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk(clk), .rst_n(rst_n), .clr(clr_tb), .div(tick_div), .tick(tick)
  );

  dsadc_cmp_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_in), .fall(fall)
  );

  assign store_zero = (st_q == PH_DONE) && is_zero_q;
  assign meas_done  = (st_q == PH_DONE) && !is_zero_q;

  dsadc_zero_store #(.ACC_W(ACC_W), .ZERO_EVERY(ZERO_EVERY)) i_zero (
    .clk(clk), .rst_n(rst_n), .mode_req(two_pass), .store(store_zero),
    .store_val(acc_q), .store_mode(two_q), .meas_done(meas_done),
    .need_zero(need_zero), .offset(offset)
  );

  always_comb begin
    integ_tgt  = two_q ? {2'b00, integ_ticks[TK_W-1:1]} : {1'b0, integ_ticks};
    integ_end  = tick && (({1'b0, tcnt_q} + (TK_W+1)'(1)) >= integ_tgt);
    short_end  = tick && (tcnt_q == TK_W'(SHORT_TICKS - 1));
    over_end   = ({1'b0, rcnt_q} + (CNT_W+1)'(1)) >= {1'b0, overshoot_clks};
    rund_limit = (rcnt_q == rundown_max - CNT_W'(1));
  end

  always_comb begin
    sel_short = (st_q == PH_SHORT);
    sel_input = (st_q == PH_INTEG) && !is_zero_q;
    sel_ref   = (st_q == PH_RUND) || (st_q == PH_OVER);
    sel_now   = {sel_input, sel_ref, sel_short};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= PH_IDLE;
      after_q   <= PH_IDLE;
      is_zero_q <= 1'b0;
      two_q     <= 1'b0;
      second_q  <= 1'b0;
      abort_q   <= 1'b0;
      rcnt_q    <= '0;
      tcnt_q    <= '0;
      acc_q     <= '0;
      res_data  <= '0;
      res_valid <= 1'b0;
      overrange <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      overrange <= 1'b0;
      unique case (st_q)
        PH_IDLE: begin
          if (conv_go) begin
            two_q     <= two_pass;
            is_zero_q <= need_zero;
            second_q  <= 1'b0;
            abort_q   <= 1'b0;
            acc_q     <= '0;
            st_q      <= PH_GAP;
            after_q   <= PH_SHORT;
          end
        end
        PH_GAP: begin
          tcnt_q <= '0;
          rcnt_q <= '0;
          st_q   <= after_q;
        end
        PH_SHORT: begin
          if (short_end) begin
            if (abort_q) begin
              st_q <= PH_IDLE;
            end else begin
              st_q    <= PH_GAP;
              after_q <= PH_INTEG;
            end
          end else if (tick) begin
            tcnt_q <= tcnt_q + TK_W'(1);
          end
        end
        PH_INTEG: begin
          if (integ_end) begin
            st_q    <= PH_GAP;
            after_q <= PH_RUND;
          end else if (tick) begin
            tcnt_q <= tcnt_q + TK_W'(1);
          end
        end
        PH_RUND: begin
          if (fall) begin
            acc_q  <= acc_q + ACC_W'(rcnt_q) + ACC_W'(1);
            rcnt_q <= '0;
            st_q   <= (two_q && !second_q) ? PH_OVER : PH_DONE;
          end else if (rund_limit) begin
            overrange <= 1'b1;
            abort_q   <= 1'b1;
            st_q      <= PH_GAP;
            after_q   <= PH_SHORT;
          end else begin
            rcnt_q <= rcnt_q + CNT_W'(1);
          end
        end
        PH_OVER: begin
          if (over_end) begin
            acc_q    <= acc_q + ACC_W'(overshoot_clks);
            second_q <= 1'b1;
            st_q     <= PH_GAP;
            after_q  <= PH_INTEG;
          end else begin
            rcnt_q <= rcnt_q + CNT_W'(1);
          end
        end
        PH_DONE: begin
          if (is_zero_q) begin
            is_zero_q <= 1'b0;
            second_q  <= 1'b0;
            acc_q     <= '0;
            st_q      <= PH_GAP;
            after_q   <= PH_SHORT;
          end else begin
            res_data  <= $signed({1'b0, acc_q}) - $signed({1'b0, offset});
            res_valid <= 1'b1;
            st_q      <= PH_IDLE;
          end
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  // R4: never two switches closed together
  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_now));
  // R4: a different select only follows an all-off cycle
  a_r4_break_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_now) != 3'b000 && sel_now != 3'b000) |-> sel_now == $past(sel_now));
  // R10: result strobe is a single clock
  a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R9: an overrange never comes with a result
  a_r9_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    overrange |-> !res_valid);
  // R9: the reference is released right after an overrange
  a_r9_ref_released: assert property (@(posedge clk) disable iff (!rst_n)
    overrange |-> !sel_ref);
endmodule

// File: tb/test_dsadc_sequencer.sv
module test_dsadc_sequencer;
  localparam int CNT_W = 12, DIV_W = 8, TK_W = 12, SHORT_TICKS = 2, ZERO_EVERY = 3;
  localparam int RES_W = CNT_W + 3;

  logic clk = 1'b0, rst_n = 1'b0, conv_go = 1'b0, two_pass = 1'b0, cmp_in = 1'b0;
  logic [DIV_W-1:0] tick_div = 8'd4;
  logic [TK_W-1:0]  integ_ticks = 12'd10;
  logic [CNT_W-1:0] overshoot_clks = 12'd7, rundown_max = 12'd200;
  logic sel_short, sel_input, sel_ref, res_valid, overrange;
  logic signed [RES_W-1:0] res_data;

  dsadc_sequencer #(.CNT_W(CNT_W), .DIV_W(DIV_W), .TK_W(TK_W),
                    .SHORT_TICKS(SHORT_TICKS), .ZERO_EVERY(ZERO_EVERY)) i_dsadc_sequencer (
    .clk(clk), .rst_n(rst_n), .conv_go(conv_go), .two_pass(two_pass),
    .tick_div(tick_div), .integ_ticks(integ_ticks), .overshoot_clks(overshoot_clks),
    .rundown_max(rundown_max), .cmp_in(cmp_in), .sel_short(sel_short),
    .sel_input(sel_input), .sel_ref(sel_ref), .res_data(res_data),
    .res_valid(res_valid), .overrange(overrange)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int md[2], zd[2];
  int in_len[64], ref_len[64], short_len[64];
  int n_in = 0, n_ref = 0, n_short = 0, n_zero = 0;
  int n_valid = 0, n_vcyc = 0, n_ovr = 0, n_ocyc = 0, last_res = 0;
  int bbm_bad = 0, multi_bad = 0, k_lat = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor and behavioral comparator
  initial begin
    logic [2:0] sel, prev_sel;
    bit p_in, p_ref, p_short, p_val, p_ovr, saw_in, cd_on;
    int r_in, r_ref, r_short, rd, cd;
    prev_sel = 0; p_in = 0; p_ref = 0; p_short = 0; p_val = 0; p_ovr = 0;
    saw_in = 0; cd_on = 0; r_in = 0; r_ref = 0; r_short = 0; rd = 0; cd = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        sel = {sel_input, sel_ref, sel_short};
        if ($countones(sel) > 1) multi_bad++;
        if (prev_sel != 0 && sel != 0 && sel != prev_sel) bbm_bad++;
        prev_sel = sel;
        if (sel_short) begin
          r_short++; cmp_in = 1'b1; saw_in = 0; rd = 0; cd_on = 0;
        end else if (p_short) begin
          short_len[n_short % 64] = r_short; n_short++; r_short = 0;
        end
        if (sel_input) begin
          saw_in = 1; r_in++;
        end else if (p_in) begin
          in_len[n_in % 64] = r_in; n_in++; r_in = 0;
        end
        if (sel_ref && !p_ref) begin
          r_ref = 1; cd = saw_in ? md[rd] : zd[rd]; cd_on = 1;
          if (!saw_in && rd == 0) n_zero++;
        end else if (sel_ref) begin
          r_ref++;
          if (cd_on) begin
            cd--;
            if (cd == 0) begin cmp_in = 1'b0; cd_on = 0; end
          end
        end else if (p_ref) begin
          ref_len[n_ref % 64] = r_ref; n_ref++; r_ref = 0; cmp_in = 1'b1;
          if (rd < 1) rd++;
        end
        if (res_valid) begin
          n_vcyc++;
          if (!p_val) begin n_valid++; last_res = int'(res_data); end
        end
        if (overrange) begin
          n_ocyc++;
          if (!p_ovr) n_ovr++;
        end
        p_in = sel_input; p_ref = sel_ref; p_short = sel_short;
        p_val = res_valid; p_ovr = overrange;
      end
    end
  end

  task automatic run_conv(input bit two, input int m0, input int m1,
                          input int z0, input int z1, input bit poke);
    int bv, bo;
    md[0] = m0; md[1] = m1; zd[0] = z0; zd[1] = z1;
    bv = n_valid; bo = n_ovr;
    @(negedge clk); two_pass = two; conv_go = 1'b1;
    @(negedge clk); conv_go = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (poke && i == 30) conv_go = 1'b1;
      if (poke && i == 31) conv_go = 1'b0;
      if (n_valid != bv || n_ovr != bo) break;
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset;
    check(!sel_short && !sel_input && !sel_ref, "R1 selects", {sel_short, sel_input, sel_ref}, 0);
    check(!res_valid && !overrange, "R1 strobes", {res_valid, overrange}, 0);
  endtask

  task automatic t_single_first;
    int bz = n_zero, bi = n_in, br = n_ref, bs = n_short, bv = n_valid;
    run_conv(1'b0, 40, 0, 5, 0, 1'b0);
    check(n_zero - bz == 1, "R6 zero on first request", n_zero - bz, 1);
    check(n_valid - bv == 1, "R10 one result", n_valid - bv, 1);
    check(last_res == 35, "R7 result", last_res, 35);
    check(short_len[bs % 64] == 8, "R2 short length", short_len[bs % 64], 8);
    check(short_len[(bs + 1) % 64] == 8, "R2 short length", short_len[(bs + 1) % 64], 8);
    check(n_in - bi == 1, "R6 zero conversion leaves input off", n_in - bi, 1);
    check(in_len[bi % 64] == 40, "R3 single integration", in_len[bi % 64], 40);
    k_lat = ref_len[(br + 1) % 64] - 40;
    check(ref_len[br % 64] - 5 == k_lat, "R5 rundown tracks comparator", ref_len[br % 64] - 5, k_lat);
  endtask

  task automatic t_negative;
    int bz = n_zero;
    run_conv(1'b0, 3, 0, 99, 0, 1'b0);
    check(n_zero == bz, "R6 no zero within period", n_zero - bz, 0);
    check(last_res == -2, "R7 negative result", last_res, -2);
  endtask

  task automatic t_busy_go;
    int bs = n_short, bv = n_valid;
    run_conv(1'b0, 10, 0, 99, 0, 1'b1);
    check(n_short - bs == 1, "R11 go ignored while busy", n_short - bs, 1);
    check(n_valid - bv == 1, "R11 single result", n_valid - bv, 1);
    check(last_res == 5, "R7 result with stored zero", last_res, 5);
  endtask

  task automatic t_zero_refresh;
    int bz = n_zero;
    run_conv(1'b0, 20, 0, 8, 0, 1'b0);
    check(n_zero - bz == 1, "R6 periodic zero", n_zero - bz, 1);
    check(last_res == 12, "R7 latest zero used", last_res, 12);
  endtask

  task automatic t_overrange;
    int bo = n_ovr, bv = n_valid, bs = n_short, br = n_ref;
    run_conv(1'b0, 1000, 0, 99, 0, 1'b0);
    check(n_ovr - bo == 1, "R9 overrange flagged", n_ovr - bo, 1);
    check(n_valid == bv, "R9 no result", n_valid - bv, 0);
    check(n_short - bs == 2, "R9 short after overrange", n_short - bs, 2);
    check(ref_len[br % 64] == 200, "R9 rundown limit", ref_len[br % 64], 200);
  endtask

  task automatic t_two_pass;
    int bz = n_zero, bi = n_in, br = n_ref;
    run_conv(1'b1, 30, 25, 4, 6, 1'b0);
    check(n_zero - bz == 1, "R6 zero on mode change", n_zero - bz, 1);
    check(last_res == 45, "R8 two-pass result", last_res, 45);
    check(in_len[bi % 64] == 20, "R3 first half integration", in_len[bi % 64], 20);
    check(in_len[(bi + 1) % 64] == 20, "R3 second half integration", in_len[(bi + 1) % 64], 20);
    check(ref_len[(br + 2) % 64] == 30 + k_lat + 7, "R8 overshoot length",
          ref_len[(br + 2) % 64], 30 + k_lat + 7);
    check(ref_len[(br + 3) % 64] == 25 + k_lat, "R8 final rundown",
          ref_len[(br + 3) % 64], 25 + k_lat);
  endtask

  task automatic t_mode_back;
    int bz = n_zero;
    run_conv(1'b0, 15, 0, 5, 0, 1'b0);
    check(n_zero - bz == 1, "R6 zero on return to single", n_zero - bz, 1);
    check(last_res == 10, "R7 result", last_res, 10);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single_first();
    t_negative();
    t_busy_go();
    t_zero_refresh();
    t_overrange();
    t_two_pass();
    t_mode_back();
    check(multi_bad == 0, "R4 one select", multi_bad, 0);
    check(bbm_bad == 0, "R4 break before make", bbm_bad, 0);
    check(n_vcyc == n_valid, "R10 strobe width", n_vcyc, n_valid);
    check(n_valid == 6, "R10 result count", n_valid, 6);
    check(n_ocyc == n_ovr, "R9 overrange width", n_ocyc, n_ovr);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule